// File: doc/BRIEF.md
# Synchronous Burst Static RAM

This block is a single-ported synchronous static RAM with four byte lanes and a depth set by a parameter. Every command input is sampled on the rising clock edge. An access begins when either of two address strobes is asserted. The core-side strobe `strobe_cpu` always reads. The controller-side strobe `strobe_ctl` follows the write controls. After a start, a 2-bit counter can step through up to four neighbouring words. Each cycle with `advance` high moves the counter on by one. A cycle without `advance` repeats the current word. A new external address may be given on any cycle, so bursts are optional.

The counter changes only the two lowest address bits. It steps either in wrap-around linear order or in XOR-interleaved order. A static mode input makes read data either flow straight from the array, or pass through an output register that adds one cycle. The output drive follows single-cycle-deselect timing: a deselect turns the outputs off right after the edge that captures it, even when registered read data is still in flight. Output enable and sleep act on the outputs without waiting for a clock edge. Sleep blocks every access and keeps the stored contents.

High impedance is represented by the drive-enable output `q_oe` being low. The value on `q` is meaningful only while `q_oe` is high.

Top module: `burst_sram`

## Requirements
- R1: After reset, and until a read is captured, `q_oe` is low.
- R2: With `seq_linear` low, the burst accesses the words whose two low address bits are `s ^ c`. Here `s` is the two low bits of the start address and `c` counts 0, 1, 2, 3 and then wraps. The upper address bits never change during a burst.
- R3: With `seq_linear` high, the two low address bits are `(s + c) mod 4`. The upper address bits never change during a burst.
- R4: A burst may be started by either strobe, and `c` advances only on cycles with `advance` high. A selected cycle with no strobe and no `advance` accesses the same word again.
- R5: A write occurs when `bw_en` is high and at least one bit of `lane_sel` is set. Lane i is bits 8i+7..8i of `din`, and only the lanes whose bit is set are changed.
- R6: With `wr_all` high, all four lanes are written, whatever `bw_en` and `lane_sel` are.
- R7: A start by `strobe_cpu` with `cs_a` high is always a read, and the write controls have no effect on it. While `cs_a` is low, `strobe_cpu` is ignored and `strobe_ctl` decides the cycle.
- R8: With `pipe_mode` low, read data of the word captured at an edge is driven on `q`, with `q_oe` high, in the cycle that follows that edge.
- R9: With `pipe_mode` high, read data passes through an output register. It appears one cycle later than with `pipe_mode` low.
- R10: A start strobe while `cs_a` and `cs_b` are not both high is a deselect. `q_oe` is low in the cycle right after the edge that captures it, in both output modes.
- R11: While `oe` is low, `q_oe` is low, and this takes effect without a clock edge.
- R12: While `sleep` is high, `q_oe` is low, no write occurs and any burst is ended. After `sleep` falls, stored data reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset of control state |
| addr | input | ADDR_W | Word address sampled at a start |
| cs_a | input | 1 | First chip enable; it also gates `strobe_cpu` |
| cs_b | input | 1 | Second chip enable |
| strobe_cpu | input | 1 | Core-side start strobe, read only |
| strobe_ctl | input | 1 | Controller-side start strobe, follows the write controls |
| advance | input | 1 | Steps the burst counter |
| bw_en | input | 1 | Byte-write enable |
| lane_sel | input | LANES | Per-lane write selects |
| wr_all | input | 1 | Global write of all lanes |
| seq_linear | input | 1 | 1 = linear burst order, 0 = interleaved burst order |
| pipe_mode | input | 1 | 1 = registered output, 0 = flow-through output |
| oe | input | 1 | Asynchronous output enable |
| sleep | input | 1 | Asynchronous low-power input |
| din | input | 8*LANES | Write data |
| q | output | 8*LANES | Read data |
| q_oe | output | 1 | Output drive enable; low stands for high impedance |

## Verification
The hardest case to reach is a deselect that lands one cycle after a read in registered mode. In that case the output must be cut off while read data is still waiting in the output register. A directed sequence builds this case on purpose: it deselects, reads twice, then deselects. Interleaved bursts from a non-zero start that wrap past the last word are also built by directed sequences, with each word preloaded with an address-derived pattern. After these, seeded random traffic mixes the strobes, chip enables, advance, lane masks, mode changes and short sleep periods. A bench model checks every cycle of that traffic.

// File: rtl/burst_sram.sv
module burst_sram #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  localparam int DW    = 8 * LANES,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              cs_a,
  input  logic              cs_b,
  input  logic              strobe_cpu,
  input  logic              strobe_ctl,
  input  logic              advance,
  input  logic              bw_en,
  input  logic [LANES-1:0]  lane_sel,
  input  logic              wr_all,
  input  logic              seq_linear,
  input  logic              pipe_mode,
  input  logic              oe,
  input  logic              sleep,
  input  logic [DW-1:0]     din,
  output logic [DW-1:0]     q,
  output logic              q_oe
);

  logic              sel, rd, pv;
  logic [ADDR_W-3:0] base;
  logic [1:0]        st, cnt;
  logic [ADDR_W-1:0] ra;
  logic [DW-1:0]     pq;
  logic [DW-1:0]     mem [DEPTH];

  wire cpu_go = strobe_cpu & cs_a;
  wire ctl_go = strobe_ctl & ~cpu_go;
  wire start  = cpu_go | ctl_go;

  wire [LANES-1:0] wmask = wr_all ? {LANES{1'b1}} : (bw_en ? lane_sel : {LANES{1'b0}});

  wire              n_sel  = start ? (cs_a & cs_b) : sel;
  wire              n_wr   = start ? (ctl_go & (|wmask)) : (|wmask);
  wire [ADDR_W-3:0] n_base = start ? addr[ADDR_W-1:2] : base;
  wire [1:0]        n_st   = start ? addr[1:0] : st;
  wire [1:0]        n_cnt  = start ? 2'd0 : cnt + {1'b0, advance};
  wire [1:0]        n_low  = seq_linear ? n_st + n_cnt : n_st ^ n_cnt;
  wire [ADDR_W-1:0] op_addr = {n_base, n_low};
  wire              go     = n_sel & ~sleep;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel  <= 1'b0;
      rd   <= 1'b0;
      pv   <= 1'b0;
      base <= '0;
      st   <= '0;
      cnt  <= '0;
      ra   <= '0;
      pq   <= '0;
    end else begin
      sel  <= go;
      rd   <= go & ~n_wr;
      pv   <= rd & ~sleep;
      base <= n_base;
      st   <= n_st;
      cnt  <= n_cnt;
      ra   <= op_addr;
      pq   <= mem[ra];
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++)
      if (go && n_wr && wmask[i])
        mem[op_addr][8*i +: 8] <= din[8*i +: 8];
  end

  assign q    = pipe_mode ? pq : mem[ra];
  assign q_oe = oe & ~sleep & (pipe_mode ? (pv & sel) : rd);

endmodule

module burst_sram_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_a,
  input logic             cs_b,
  input logic             strobe_cpu,
  input logic             strobe_ctl,
  input logic             wr_all,
  input logic [LANES-1:0] lane_sel,
  input logic             pipe_mode,
  input logic             oe,
  input logic             sleep,
  input logic             q_oe
);

  wire cpu_start = strobe_cpu & cs_a;
  wire desel = (cpu_start & ~cs_b) | (~cpu_start & strobe_ctl & ~(cs_a & cs_b));

  p_desel_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    desel |=> !q_oe);

  p_oe_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> !q_oe);

  p_sleep_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !q_oe);

  p_flow_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && !sleep && cpu_start && cs_b) |=> (pipe_mode || !oe || sleep || q_oe));

  p_cpu_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && !sleep && cpu_start && cs_b && (wr_all || (|lane_sel)))
      |=> (pipe_mode || !oe || sleep || q_oe));

endmodule

bind burst_sram burst_sram_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_a(cs_a), .cs_b(cs_b),
  .strobe_cpu(strobe_cpu), .strobe_ctl(strobe_ctl), .wr_all(wr_all),
  .lane_sel(lane_sel), .pipe_mode(pipe_mode), .oe(oe), .sleep(sleep), .q_oe(q_oe)
);

// File: tb/burst_sram_test.sv
`timescale 1ns/1ps
module burst_sram_test;

  localparam int AW = 6;
  localparam int DEP = 1 << AW;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] addr = '0;
  logic cs_a = 0, cs_b = 0, strobe_cpu = 0, strobe_ctl = 0, advance = 0;
  logic bw_en = 0, wr_all = 0, seq_linear = 0, pipe_mode = 0, oe = 1, sleep = 0;
  logic [3:0]  lane_sel = '0;
  logic [31:0] din = '0;
  logic [31:0] q;
  logic        q_oe;

  int checks = 0, fails = 0;
  bit done = 0;

  burst_sram #(.ADDR_W(AW), .LANES(4)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .cs_a(cs_a), .cs_b(cs_b),
    .strobe_cpu(strobe_cpu), .strobe_ctl(strobe_ctl), .advance(advance),
    .bw_en(bw_en), .lane_sel(lane_sel), .wr_all(wr_all), .seq_linear(seq_linear),
    .pipe_mode(pipe_mode), .oe(oe), .sleep(sleep), .din(din), .q(q), .q_oe(q_oe)
  );

  always #2.5 clk = ~clk;

  // reference model state
  logic m_sel = 0, m_rd = 0, m_pv = 0;
  logic [AW-3:0] m_base = '0;
  logic [1:0] m_st = '0, m_cnt = '0;
  logic [AW-1:0] m_ra = '0;
  logic [31:0] m_pq = '0;
  logic [31:0] mm [DEP];

  function automatic logic [31:0] pat(input int a);
    return 32'h9E37_79B9 * (a + 1);
  endfunction

  task automatic model();
    logic cg, tg, go, nsel, nwr;
    logic [3:0] mask;
    logic [1:0] nlow;
    logic [AW-1:0] oa;
    cg = strobe_cpu & cs_a;
    tg = strobe_ctl & !cg;
    mask = wr_all ? 4'hF : (bw_en ? lane_sel : 4'h0);
    m_pq = mm[m_ra];
    if (cg || tg) begin
      nsel = cs_a & cs_b; nwr = tg & (|mask);
      m_base = addr[AW-1:2]; m_st = addr[1:0]; m_cnt = 0;
    end else begin
      nsel = m_sel; nwr = |mask;
      if (advance) m_cnt = m_cnt + 1;
    end
    nlow = seq_linear ? m_st + m_cnt : m_st ^ m_cnt;
    oa = {m_base, nlow};
    go = nsel & !sleep;
    if (go && nwr)
      for (int i = 0; i < 4; i++) if (mask[i]) mm[oa][8*i +: 8] = din[8*i +: 8];
    m_pv = m_rd & !sleep;
    m_sel = go;
    m_rd = go & !nwr;
    m_ra = oa;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    logic eo;
    logic [31:0] eq;
    eo = oe & !sleep & (pipe_mode ? (m_pv & m_sel) : m_rd);
    eq = pipe_mode ? m_pq : mm[m_ra];
    chk({tag, " q_oe"}, {31'b0, q_oe}, {31'b0, eo});
    if (eo) chk({tag, " q"}, q, eq);
  endtask

  task automatic tick(input string tag);
    @(posedge clk);
    model();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle();
    strobe_cpu = 0; strobe_ctl = 0; advance = 0; bw_en = 0; wr_all = 0; lane_sel = 0;
  endtask

  task automatic rd_cpu(input int a);
    idle(); cs_a = 1; cs_b = 1; strobe_cpu = 1; addr = a[AW-1:0];
  endtask

  task automatic deselect();
    idle(); cs_a = 1; cs_b = 0; strobe_ctl = 1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4321));
    repeat (3) @(negedge clk);
    chk("R1 reset q_oe", {31'b0, q_oe}, 32'd0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 idle q_oe", {31'b0, q_oe}, 32'd0);

    // R6 preload by global write, lane selects off
    for (int a = 0; a < DEP; a++) begin
      idle(); cs_a = 1; cs_b = 1; strobe_ctl = 1; wr_all = 1; addr = a[AW-1:0]; din = pat(a);
      tick("R6 preload");
    end
    rd_cpu(9); tick("R8 read");
    chk("R6 global write data", q, pat(9));
    chk("R8 flow same cycle", {31'b0, q_oe}, 32'd1);

    // R5 byte lanes 0 and 2
    idle(); cs_a = 1; cs_b = 1; strobe_ctl = 1; bw_en = 1; lane_sel = 4'b0101; addr = 10; din = 32'hFFFF_FFFF;
    tick("R5 write");
    rd_cpu(10); tick("R5 read");
    chk("R5 lane mask", q, (pat(10) & 32'hFF00_FF00) | 32'h00FF_00FF);

    // R7 cpu strobe ignores write controls
    rd_cpu(11); wr_all = 1; din = 32'h0; tick("R7");
    chk("R7 cpu start reads", q, pat(11));
    rd_cpu(11); tick("R7 reread");
    chk("R7 data unchanged", q, pat(11));
    idle(); cs_a = 0; cs_b = 1; strobe_cpu = 1; strobe_ctl = 1; addr = 12; tick("R7 cs_a low");
    chk("R7 cpu strobe ignored, ctl deselects", {31'b0, q_oe}, 32'd0);

    // R2 interleaved from low bits 01
    seq_linear = 0;
    rd_cpu(13); tick("R2 start");
    chk("R2 first", q, pat(13));
    idle(); advance = 1;
    tick("R2"); chk("R2 step1", q, pat(12));
    tick("R2"); chk("R2 step2", q, pat(15));
    tick("R2"); chk("R2 step3", q, pat(14));
    tick("R2"); chk("R2 wrap", q, pat(13));

    // R3 linear from low bits 01
    seq_linear = 1;
    rd_cpu(13); tick("R3 start");
    idle(); advance = 1;
    tick("R3"); chk("R3 step1", q, pat(14));
    tick("R3"); chk("R3 step2", q, pat(15));
    tick("R3"); chk("R3 step3", q, pat(12));

    // R4 hold without advance, start by ctl strobe
    idle(); tick("R4 hold"); chk("R4 hold same word", q, pat(12));
    idle(); cs_a = 1; cs_b = 1; strobe_ctl = 1; addr = 20; tick("R4 ctl start");
    chk("R4 ctl strobe read", q, pat(20));
    idle(); advance = 1; tick("R4 adv"); chk("R4 ctl burst step", q, pat(21));

    // R11 asynchronous output enable
    idle();
    oe = 0; #1; chk("R11 oe low", {31'b0, q_oe}, 32'd0);
    oe = 1; #1; chk("R11 oe high", {31'b0, q_oe}, 32'd1);

    // R9 / R10 pipelined with single-cycle deselect
    deselect(); tick("R10 desel flow");
    chk("R10 flow off", {31'b0, q_oe}, 32'd0);
    pipe_mode = 1;
    rd_cpu(30); tick("R9 first");
    chk("R9 not yet", {31'b0, q_oe}, 32'd0);
    rd_cpu(31); tick("R9 second");
    chk("R9 one cycle later", q, pat(30));
    chk("R9 driven", {31'b0, q_oe}, 32'd1);
    deselect(); tick("R10 pipe");
    chk("R10 off before pending data", {31'b0, q_oe}, 32'd0);
    pipe_mode = 0;

    // R12 sleep
    sleep = 1;
    idle(); cs_a = 1; cs_b = 1; strobe_ctl = 1; wr_all = 1; addr = 40; din = 32'h0;
    tick("R12 sleep write");
    chk("R12 off in sleep", {31'b0, q_oe}, 32'd0);
    sleep = 0;
    rd_cpu(40); tick("R12 wake");
    chk("R12 data kept", q, pat(40));

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      int r;
      idle();
      r = $urandom % 100;
      cs_a = ($urandom % 8) != 0;
      cs_b = ($urandom % 8) != 0;
      strobe_cpu = r < 25;
      strobe_ctl = (r >= 20) && (r < 50);
      advance = ($urandom % 2) == 1;
      r = $urandom % 100;
      bw_en = r < 30;
      lane_sel = 4'($urandom);
      wr_all = r > 90;
      addr = AW'($urandom);
      din = $urandom;
      oe = ($urandom % 10) != 0;
      sleep = ($urandom % 40) == 0;
      if ($urandom % 50 == 0) pipe_mode = ~pipe_mode;
      if ($urandom % 50 == 0) seq_linear = ~seq_linear;
      tick("R2 R3 R4 R5 R8 R9 R10 R12 random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule